// File: doc/BRIEF.md
# Fast-Clear Tracker and Resolver

This block sits in front of a small on-chip surface memory. It keeps a compact per-pair metadata code beside the memory, where a pair is two consecutive lines. Each line stands for one 64-byte cache line, so each metadata code covers 128 bytes. With a one-bit code the metadata is 1/1024 the size of the surface. A fast clear records a colour and marks every pair as cleared in a single cycle. It does not write the surface memory. Any read of a marked pair returns the recorded colour, and the stored data of that pair is ignored.

A resolve command walks the pairs in index order. It writes the clear colour into both lines of every marked pair and then returns the pair's code to pass-through, so afterwards the memory alone holds the true image. A line write to a marked pair also writes the colour into the other line of the pair, so the pair is never half valid.

The block has a command port (clear, resolve) and a line-granular access port for reads and writes. A `busy` flag and a one-cycle `done` pulse show when a resolve has finished. Requests that arrive while the block is busy are held off through the ready signals. They are never dropped.

Top module: `fclr_tracker`

## Requirements
- R1: After reset every pair is pass-through, `busy` and `done` are low, `cmd_ready` is high and `rd_valid` is low. A line write issued straight after reset causes no fill cycle.
- R2: A clear command (`cmd_op` = 0) is accepted in one cycle. It records `cmd_color` and sets every pair's code to all ones. It writes nothing to the surface memory and does not raise `busy`.
- R3: An accepted read gives `rd_valid` high exactly one cycle later. `rd_data` is then the clear colour if the pair's code is all ones, and the stored line otherwise.
- R4: A line address splits into a pair index (`acc_addr[AW-1:1]`) and a line select (`acc_addr[0]`). A write to a pass-through pair stores only the addressed line, takes no busy cycle, and leaves the other line unchanged.
- R5: A write to a marked pair stores the addressed line. In the following single busy cycle it fills the other line of the pair (address bit 0 inverted) with the clear colour. The pair then becomes pass-through.
- R6: A resolve command (`cmd_op` = 1) spends one cycle on each pass-through pair and two cycles on each marked pair, writing the colour to both of its lines. `busy` stays high for NUM_PAIRS plus the number of marked pairs. In the next cycle `busy` is low, `done` is high for one cycle, and every pair is pass-through.
- R7: While `busy` is high, `cmd_ready` and `acc_ready` are low. A request held on its valid is accepted later and is not lost.
- R8: When `cmd_valid` and `acc_valid` are both high while the block is idle, the command is taken first and `acc_ready` is low in that cycle.
- R9: `META_BITS` selects a one-bit or two-bit code per pair. The code all ones means cleared and all zeros means resolved or pass-through. The behaviour at the ports is the same for both widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 1 | 0 = fast clear, 1 = resolve |
| cmd_color | input | LINE_W | Colour recorded by a clear |
| cmd_ready | output | 1 | Command accepted this cycle when high with `cmd_valid` |
| acc_valid | input | 1 | Line access request |
| acc_write | input | 1 | 1 = write line, 0 = read line |
| acc_addr | input | AW | Line address: pair index above bit 0 |
| acc_wdata | input | LINE_W | Write data |
| acc_ready | output | 1 | Access accepted this cycle when high with `acc_valid` |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | LINE_W | Read result |
| busy | output | 1 | Resolve or fill in progress |
| done | output | 1 | One-cycle pulse after a resolve finishes |

## Verification
The bench aims at these corner cases:
- A single-line write into a cleared pair. A design without the sibling fill would later return stale memory for the other line.
- Clears issued over written data. A design that does not ignore the stored data of a marked pair would leak old lines.
- Resolves with none, some and all pairs marked, with the busy length counted exactly. An off-by-one in the walk would skip the last pair or pulse `done` early.
- Requests held across busy periods and a command colliding with an access. A design that dropped either would lose data or reorder the clear against the read.

// File: rtl/fclr_pkg.sv
package fclr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FILL     = 2'd1,
        ST_RSV_SCAN = 2'd2,
        ST_RSV_HI   = 2'd3
    } fclr_state_e;

    typedef enum logic {
        OP_CLEAR   = 1'b0,
        OP_RESOLVE = 1'b1
    } fclr_op_e;
endpackage

// File: rtl/fclr_meta.sv
module fclr_meta #(
    parameter int NUM_PAIRS = 16,
    parameter int META_BITS = 1,
    localparam int PW = $clog2(NUM_PAIRS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_all,
    input  logic                 clr_en,
    input  logic [PW-1:0]        clr_idx,
    output logic [NUM_PAIRS-1:0] flags
);
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic [META_BITS-1:0] code;
        always_ff @(posedge clk) begin
            if (!rst_n)
                code <= '0;
            else if (set_all)
                code <= '1;
            else if (clr_en && clr_idx == PW'(g))
                code <= '0;
        end
        assign flags[g] = &code;
    end
endmodule

// File: rtl/fclr_surface.sv
module fclr_surface #(
    parameter int LINE_W = 32,
    parameter int LINES  = 32,
    localparam int AW = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [LINE_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [LINE_W-1:0] rdata
);
    logic [LINE_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/fclr_ctrl.sv
module fclr_ctrl
    import fclr_pkg::*;
#(
    parameter int LINE_W    = 32,
    parameter int NUM_PAIRS = 16,
    localparam int PW = $clog2(NUM_PAIRS),
    localparam int AW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_op,
    input  logic [LINE_W-1:0]    cmd_color,
    output logic                 cmd_ready,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [AW-1:0]        acc_addr,
    input  logic [LINE_W-1:0]    acc_wdata,
    output logic                 acc_ready,
    input  logic [NUM_PAIRS-1:0] flags,
    output logic                 busy,
    output logic                 done,
    output logic                 rd_valid,
    output logic                 rd_use_clr,
    output logic [LINE_W-1:0]    colour,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_waddr,
    output logic [LINE_W-1:0]    mem_wdata,
    output logic                 mem_re,
    output logic [AW-1:0]        mem_raddr,
    output logic                 meta_set_all,
    output logic                 meta_clr_en,
    output logic [PW-1:0]        meta_clr_idx
);
    fclr_state_e state, state_nx;

    logic [PW-1:0]     ptr;
    logic [AW-1:0]     fill_addr;
    logic [LINE_W-1:0] colour_q;
    logic              done_q, rd_valid_q, rd_clr_q;

    logic [PW-1:0] acc_pair;
    logic          cmd_fire, acc_fire, ptr_last, walk_end, walk_step;

    assign acc_pair  = acc_addr[AW-1:1];
    assign cmd_fire  = cmd_valid && (state == ST_IDLE);
    assign acc_fire  = acc_valid && !cmd_valid && (state == ST_IDLE);
    assign ptr_last  = (ptr == PW'(NUM_PAIRS - 1));
    assign walk_end  = ((state == ST_RSV_SCAN) && !flags[ptr] && ptr_last) ||
                       ((state == ST_RSV_HI) && ptr_last);
    assign walk_step = ((state == ST_RSV_SCAN) && !flags[ptr] && !ptr_last) ||
                       ((state == ST_RSV_HI) && !ptr_last);

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_fire) begin
                    if (fclr_op_e'(cmd_op) == OP_RESOLVE)
                        state_nx = ST_RSV_SCAN;
                end else if (acc_fire && acc_write && flags[acc_pair]) begin
                    state_nx = ST_FILL;
                end
            end
            ST_FILL:     state_nx = ST_IDLE;
            ST_RSV_SCAN: begin
                if (flags[ptr])
                    state_nx = ST_RSV_HI;
                else if (ptr_last)
                    state_nx = ST_IDLE;
            end
            ST_RSV_HI:   state_nx = ptr_last ? ST_IDLE : ST_RSV_SCAN;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // walk pointer, recorded colour, read tag, fill target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            fill_addr  <= '0;
            colour_q   <= '0;
            done_q     <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_clr_q   <= 1'b0;
        end else begin
            done_q     <= walk_end;
            rd_valid_q <= acc_fire && !acc_write;
            if (acc_fire)
                rd_clr_q <= flags[acc_pair];
            if (acc_fire && acc_write)
                fill_addr <= {acc_addr[AW-1:1], ~acc_addr[0]};
            if (cmd_fire && fclr_op_e'(cmd_op) == OP_CLEAR)
                colour_q <= cmd_color;
            if (cmd_fire)
                ptr <= '0;
            else if (walk_step)
                ptr <= ptr + 1'b1;
        end
    end

    // outputs by state
    always_comb begin
        cmd_ready    = 1'b0;
        acc_ready    = 1'b0;
        busy         = 1'b1;
        mem_we       = 1'b0;
        mem_waddr    = '0;
        mem_wdata    = colour_q;
        mem_re       = 1'b0;
        mem_raddr    = acc_addr;
        meta_set_all = 1'b0;
        meta_clr_en  = 1'b0;
        meta_clr_idx = acc_pair;
        unique case (state)
            ST_IDLE: begin
                busy         = 1'b0;
                cmd_ready    = 1'b1;
                acc_ready    = !cmd_valid;
                meta_set_all = cmd_fire && (fclr_op_e'(cmd_op) == OP_CLEAR);
                if (acc_fire) begin
                    if (acc_write) begin
                        mem_we      = 1'b1;
                        mem_waddr   = acc_addr;
                        mem_wdata   = acc_wdata;
                        meta_clr_en = 1'b1;
                    end else begin
                        mem_re = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                mem_we    = 1'b1;
                mem_waddr = fill_addr;
            end
            ST_RSV_SCAN: begin
                mem_we    = flags[ptr];
                mem_waddr = {ptr, 1'b0};
            end
            ST_RSV_HI: begin
                mem_we       = 1'b1;
                mem_waddr    = {ptr, 1'b1};
                meta_clr_en  = 1'b1;
                meta_clr_idx = ptr;
            end
            default: busy = 1'b0;
        endcase
    end

    assign done       = done_q;
    assign rd_valid   = rd_valid_q;
    assign rd_use_clr = rd_clr_q;
    assign colour     = colour_q;
endmodule

// File: rtl/fclr_tracker.sv
module fclr_tracker #(
    parameter int LINE_W    = 32,
    parameter int NUM_PAIRS = 16,
    parameter int META_BITS = 1,
    localparam int LINES = 2 * NUM_PAIRS,
    localparam int AW    = $clog2(LINES),
    localparam int PW    = $clog2(NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [LINE_W-1:0] cmd_color,
    output logic              cmd_ready,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [AW-1:0]     acc_addr,
    input  logic [LINE_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              rd_valid,
    output logic [LINE_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);
    logic [NUM_PAIRS-1:0] pair_flags;
    logic                 rd_use_clr;
    logic [LINE_W-1:0]    colour, mem_rdata, mem_wdata;
    logic                 mem_we, mem_re;
    logic [AW-1:0]        mem_waddr, mem_raddr;
    logic                 meta_set_all, meta_clr_en;
    logic [PW-1:0]        meta_clr_idx;

    fclr_ctrl #(.LINE_W(LINE_W), .NUM_PAIRS(NUM_PAIRS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_color(cmd_color),
        .cmd_ready(cmd_ready),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_ready(acc_ready),
        .flags(pair_flags), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_use_clr(rd_use_clr), .colour(colour),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr),
        .meta_set_all(meta_set_all), .meta_clr_en(meta_clr_en),
        .meta_clr_idx(meta_clr_idx)
    );

    fclr_meta #(.NUM_PAIRS(NUM_PAIRS), .META_BITS(META_BITS)) u_meta (
        .clk(clk), .rst_n(rst_n),
        .set_all(meta_set_all), .clr_en(meta_clr_en), .clr_idx(meta_clr_idx),
        .flags(pair_flags)
    );

    fclr_surface #(.LINE_W(LINE_W), .LINES(LINES)) u_surf (
        .clk(clk),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
    );

    assign rd_data = rd_use_clr ? colour : mem_rdata;
endmodule

// File: rtl/fclr_checker.sv
module fclr_checker #(
    parameter int NUM_PAIRS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic                 cmd_op,
    input logic                 acc_valid,
    input logic                 acc_ready,
    input logic                 acc_write,
    input logic                 busy,
    input logic                 done,
    input logic                 rd_valid,
    input logic [NUM_PAIRS-1:0] flags,
    input logic                 mem_we
);
    AST_CLEAR_MARKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_op) |=> (&flags)); // R2
    AST_CLEAR_NO_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_op) |-> !mem_we); // R2
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_write) |=> rd_valid); // R3
    AST_RESOLVE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags == '0)); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_BUSY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!cmd_ready && !acc_ready)); // R7
    AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |-> !acc_ready); // R8
endmodule

bind fclr_tracker fclr_checker #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .busy(busy), .done(done), .rd_valid(rd_valid),
    .flags(pair_flags), .mem_we(mem_we)
);

// File: tb/fclr_tracker_test.sv
module fclr_tracker_test;
    localparam int LW = 32;
    localparam int NP = 8;
    localparam int NL = 2 * NP;
    localparam int AW = $clog2(NL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cmd_valid = 0, cmd_op = 0, acc_valid = 0, acc_write = 0;
    logic [LW-1:0] cmd_color = '0, acc_wdata = '0;
    logic [AW-1:0] acc_addr = '0;
    logic          cmd_ready, acc_ready, rd_valid, busy, done;
    logic [LW-1:0] rd_data;
    logic          cmd_ready_b, acc_ready_b, rd_valid_b, busy_b, done_b;
    logic [LW-1:0] rd_data_b;

    fclr_tracker #(.LINE_W(LW), .NUM_PAIRS(NP), .META_BITS(1)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_color(cmd_color), .cmd_ready(cmd_ready), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done));

    fclr_tracker #(.LINE_W(LW), .NUM_PAIRS(NP), .META_BITS(2)) uut_w2 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_color(cmd_color), .cmd_ready(cmd_ready_b), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready_b), .rd_valid(rd_valid_b), .rd_data(rd_data_b),
        .busy(busy_b), .done(done_b));

    int checks = 0;
    int failures = 0;
    logic [LW-1:0] ref_mem [NL];
    logic          ref_flag [NP];
    logic [LW-1:0] ref_col;
    logic [15:0]   lf = 16'hACE1;

    task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int count_flags();
        int n = 0;
        for (int p = 0; p < NP; p++) if (ref_flag[p]) n++;
        return n;
    endfunction

    task automatic do_clear(input logic [LW-1:0] c);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 0; cmd_color = c; #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cmd_valid = 0;
        ref_col = c;
        for (int p = 0; p < NP; p++) ref_flag[p] = 1'b1;
        check("R2 clear leaves busy low", {31'd0, busy}, 32'd0);
        check("R9 clear busy low (2-bit)", {31'd0, busy_b}, 32'd0);
    endtask

    task automatic do_resolve();
        int n, exp_n, held;
        exp_n = NP + count_flags();
        @(negedge clk);
        cmd_valid = 1; cmd_op = 1; #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cmd_valid = 0;
        n = 0; held = 0;
        while (busy && n < 4 * NP) begin
            if (cmd_ready || acc_ready) held++;
            n++;
            @(negedge clk);
        end
        check("R6 resolve busy length", n, exp_n);
        check("R7 ready low while busy", held, 0);
        check("R6 done pulse after resolve", {31'd0, done}, 32'd1);
        check("R9 done pulse (2-bit)", {31'd0, done_b}, 32'd1);
        @(negedge clk);
        check("R6 done one cycle only", {31'd0, done}, 32'd0);
        for (int p = 0; p < NP; p++) begin
            if (ref_flag[p]) begin
                ref_mem[2*p] = ref_col;
                ref_mem[2*p+1] = ref_col;
                ref_flag[p] = 1'b0;
            end
        end
    endtask

    task automatic do_write(input int a, input logic [LW-1:0] d);
        logic exp_fill;
        exp_fill = ref_flag[a/2];
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = AW'(a); acc_wdata = d; #1;
        while (!acc_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        acc_valid = 0;
        if (exp_fill)
            check("R5 fill cycle after write to marked pair", {31'd0, busy}, 32'd1);
        else
            check("R4 no fill after write to pass-through pair", {31'd0, busy}, 32'd0);
        ref_mem[a] = d;
        if (exp_fill) begin
            ref_mem[a ^ 1] = ref_col;
            ref_flag[a/2] = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    task automatic do_read(input int a, input string req);
        logic [LW-1:0] exp;
        exp = ref_flag[a/2] ? ref_col : ref_mem[a];
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = AW'(a); #1;
        while (!acc_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        acc_valid = 0;
        check({req, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
        check(req, rd_data, exp);
        check({req, " R9 2-bit"}, rd_data_b, exp);
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < NL; a++) do_read(a, req);
    endtask

    task automatic lf_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 cmd_ready after reset", {31'd0, cmd_ready}, 32'd1);
        check("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        for (int p = 0; p < NP; p++) ref_flag[p] = 1'b0;
        ref_col = '0;
        do_write(0, 32'h0000_1111);   // R1: pass-through, no fill
        do_read(0, "R1 write after reset");

        do_clear(32'hC0C0_0001);
        read_all("R3 read of cleared surface");

        for (int p = 0; p < NP; p += 2) do_write(2*p, 32'hA000_0000 + 32'(p));
        read_all("R5 sibling filled with colour");

        do_clear(32'hC0C0_0002);
        read_all("R3 marked pair ignores stored data");

        for (int p = 1; p < NP; p += 2) do_write(2*p + 1, 32'hB000_0000 + 32'(p));
        do_resolve();
        read_all("R6 data after partial resolve");

        for (int a = 0; a < NL; a++) do_write(a, 32'hD000_0000 + 32'(a));
        read_all("R4 line writes to pass-through pairs");
        do_resolve();

        do_clear(32'hC0C0_0003);
        do_resolve();
        read_all("R6 full resolve materialises colour");

        // R8: command and access collide
        @(negedge clk);
        cmd_valid = 1; cmd_op = 0; cmd_color = 32'hC0C0_0004;
        acc_valid = 1; acc_write = 0; acc_addr = AW'(5); #1;
        check("R8 acc_ready low on collision", {31'd0, acc_ready}, 32'd0);
        check("R8 cmd_ready high on collision", {31'd0, cmd_ready}, 32'd1);
        @(negedge clk);
        cmd_valid = 0; #1;
        ref_col = 32'hC0C0_0004;
        for (int p = 0; p < NP; p++) ref_flag[p] = 1'b1;
        while (!acc_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        acc_valid = 0;
        check("R8 held read sees new clear", rd_data, 32'hC0C0_0004);

        // R7: access held across a resolve
        @(negedge clk);
        cmd_valid = 1; cmd_op = 1; #1;
        @(negedge clk);
        cmd_valid = 0;
        acc_valid = 1; acc_write = 0; acc_addr = AW'(9); #1;
        check("R7 access held off during resolve", {31'd0, acc_ready}, 32'd0);
        for (int p = 0; p < NP; p++) begin
            ref_mem[2*p] = ref_col; ref_mem[2*p+1] = ref_col; ref_flag[p] = 1'b0;
        end
        while (!acc_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        acc_valid = 0;
        check("R7 held read completes", {31'd0, rd_valid}, 32'd1);
        check("R7 held read data", rd_data, ref_col);

        // mixed sequence against the reference
        for (int i = 0; i < 400; i++) begin
            lf_step();
            case (lf[3:0])
                4'd0: do_clear({lf, ~lf});
                4'd1: do_resolve();
                4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7:
                    do_write(int'(lf[7:4]) % NL, {lf[15:8], lf, lf[7:0]});
                default: do_read(int'(lf[7:4]) % NL, "R3 mixed sequence read");
            endcase
        end
        read_all("R3 final sweep");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule